// File: doc/BRIEF.md
# Dual-Width Cache Data RAM

This block is the data store of one cache level: 32 rows of 64 bits behind a single storage port. Two paths reach that port, and each has its own data pins. The processor side uses a fast path. It reads or writes one 4-bit nibble per cycle, with a separate nibble input bus and nibble output bus. Fast reads are pipelined, so one access can be issued every cycle.

The refill and write-back side uses a wide path. It moves a whole 64-bit row in one operation over a bidirectional bus. The block drives that bus only in the cycle that returns wide read data. In every other cycle the bus is left at high impedance.

Only one operation reaches the array in a cycle. A wide request always wins that cycle. A fast request presented in the same cycle is refused and flagged as stalled, and the requester must present it again.

Top module: `dual_width_cache_ram`

## Requirements
- R1: The fast address is 9 bits. Bits 8:4 select one of 32 rows and bits 3:0 select one of 16 nibbles. Nibble n is row bits 4n+3:4n, so nibble 0 is bits 3:0.
- R2: A fast write changes only the addressed nibble. The other 60 bits of that row keep their values.
- R3: A fast read presents the addressed nibble on `nib_rdata`, with `nib_rvalid` high, in the cycle after the request. Reads issued on consecutive cycles each return in turn. `nib_rvalid` is never high without a read issued one cycle earlier.
- R4: A wide write stores all 64 bits sampled from `row_bus` into the addressed row in one cycle.
- R5: A wide read drives the addressed row's full contents onto `row_bus` during the cycle after the request.
- R6: The block drives `row_bus` only in the cycle after a wide read. In all other cycles the bus is released, so a value from another driver appears on it unchanged.
- R7: The two paths share one array. A row filled by 16 fast writes reads back whole over the wide path. A row written wide reads back nibble by nibble over the fast path.
- R8: When a fast and a wide request arrive in the same cycle, the wide request is served and `nib_stall` is high in that cycle. The fast request has no effect: no nibble is written and no `nib_rvalid` follows. `nib_stall` is low whenever no wide request is present.
- R9: While `rst` is high and in the first cycle after it, `nib_rvalid` is low and `row_bus` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_req | input | 1 | Fast-path request |
| nib_wr | input | 1 | Fast-path request is a write (1) or a read (0) |
| nib_addr | input | 9 | Fast address: row in bits 8:4, nibble in bits 3:0 |
| nib_wdata | input | 4 | Fast write nibble |
| nib_rdata | output | 4 | Fast read nibble |
| nib_rvalid | output | 1 | `nib_rdata` holds the result of the previous cycle's read |
| nib_stall | output | 1 | Fast request refused this cycle because a wide request is present |
| row_req | input | 1 | Wide-path request |
| row_wr | input | 1 | Wide request is a write (1) or a read (0) |
| row_sel | input | 5 | Wide-path row index |
| row_bus | inout | 64 | Bidirectional row data bus |

## Verification
The array is first filled by wide writes with a distinct pattern in each row, so every later read has a known expected value. Back-to-back fast reads, including the last nibble of the last row, check the one-cycle pipeline and the nibble positions. A fast write followed by a wide read shows that only one nibble moved. A row built from 16 fast writes, and a wide-written row read back as 16 nibbles, show that both paths reach the same storage. Requests from both paths in the same cycle, once with a fast write and once with a fast read, separate correct priority from a lost or leaked fast access. Idle cycles and reset cycles, with the bench driving the bus itself, show whether the block releases the bus.

// File: rtl/cram_pkg.sv
package cram_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_NIB_RD,
    OP_NIB_WR,
    OP_ROW_RD,
    OP_ROW_WR
  } cram_op_e;
endpackage

// File: rtl/cram_arbiter.sv
module cram_arbiter
  import cram_pkg::*;
(
  input  logic     nib_req,
  input  logic     nib_wr,
  input  logic     row_req,
  input  logic     row_wr,
  output cram_op_e op,
  output logic     nib_stall
);
  always_comb begin
    op = OP_IDLE;
    if (row_req)      op = row_wr ? OP_ROW_WR : OP_ROW_RD;
    else if (nib_req) op = nib_wr ? OP_NIB_WR : OP_NIB_RD;
  end

  assign nib_stall = nib_req & row_req;
endmodule

// File: rtl/cram_array.sv
module cram_array #(
  parameter int ROWS  = 32,
  parameter int ROW_W = 64,
  parameter int NIB_W = 4,
  localparam int NIBS = ROW_W / NIB_W,
  localparam int RAW  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [RAW-1:0]   row,
  input  logic [NIBS-1:0]  nib_we,
  input  logic [ROW_W-1:0] wdata,
  output logic [ROW_W-1:0] rdata
);
  logic [ROW_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NIBS; i++) begin
      if (nib_we[i]) mem[row][i*NIB_W +: NIB_W] <= wdata[i*NIB_W +: NIB_W];
    end
    if (rd_en) rdata <= mem[row];
  end
endmodule

// File: rtl/cram_wide_io.sv
module cram_wide_io #(
  parameter int ROW_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_issue,
  input  logic [ROW_W-1:0] rdata,
  inout  wire  [ROW_W-1:0] bus,
  output logic [ROW_W-1:0] bus_in,
  output logic             oe
);
  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= rd_issue;
  end

  assign bus    = oe ? rdata : {ROW_W{1'bz}};
  assign bus_in = bus;
endmodule

// File: rtl/dual_width_cache_ram.sv
module dual_width_cache_ram
  import cram_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int ROW_W = 64,
  parameter int NIB_W = 4,
  localparam int NIBS   = ROW_W / NIB_W,
  localparam int RAW    = $clog2(ROWS),
  localparam int NAW    = $clog2(NIBS),
  localparam int ADDR_W = RAW + NAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nib_req,
  input  logic              nib_wr,
  input  logic [ADDR_W-1:0] nib_addr,
  input  logic [NIB_W-1:0]  nib_wdata,
  output logic [NIB_W-1:0]  nib_rdata,
  output logic              nib_rvalid,
  output logic              nib_stall,
  input  logic              row_req,
  input  logic              row_wr,
  input  logic [RAW-1:0]    row_sel,
  inout  wire  [ROW_W-1:0]  row_bus
);
  cram_op_e         op;
  logic [RAW-1:0]   port_row;
  logic [NAW-1:0]   nib_idx;
  logic [NIBS-1:0]  nib_we;
  logic [ROW_W-1:0] port_wdata;
  logic [ROW_W-1:0] rd_q;
  logic [ROW_W-1:0] bus_in;
  logic             rd_en;
  logic             wb_oe;
  logic [NAW-1:0]   nib_q;

  cram_arbiter u_arb (
    .nib_req   (nib_req),
    .nib_wr    (nib_wr),
    .row_req   (row_req),
    .row_wr    (row_wr),
    .op        (op),
    .nib_stall (nib_stall)
  );

  assign nib_idx  = nib_addr[NAW-1:0];
  assign port_row = (op == OP_ROW_RD || op == OP_ROW_WR) ? row_sel
                                                         : nib_addr[ADDR_W-1:NAW];
  assign rd_en    = (op == OP_NIB_RD) || (op == OP_ROW_RD);

  always_comb begin
    nib_we     = '0;
    port_wdata = {NIBS{nib_wdata}};
    case (op)
      OP_NIB_WR: nib_we[nib_idx] = 1'b1;
      OP_ROW_WR: begin
        nib_we     = '1;
        port_wdata = bus_in;
      end
      default: ;
    endcase
  end

  cram_array #(.ROWS(ROWS), .ROW_W(ROW_W), .NIB_W(NIB_W)) u_array (
    .clk    (clk),
    .rd_en  (rd_en),
    .row    (port_row),
    .nib_we (nib_we),
    .wdata  (port_wdata),
    .rdata  (rd_q)
  );

  cram_wide_io #(.ROW_W(ROW_W)) u_wide (
    .clk      (clk),
    .rst      (rst),
    .rd_issue (op == OP_ROW_RD),
    .rdata    (rd_q),
    .bus      (row_bus),
    .bus_in   (bus_in),
    .oe       (wb_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_rvalid <= 1'b0;
      nib_q      <= '0;
    end else begin
      nib_rvalid <= (op == OP_NIB_RD);
      if (op == OP_NIB_RD) nib_q <= nib_idx;
    end
  end

  logic [NIB_W-1:0] nib_slice [NIBS];
  for (genvar g = 0; g < NIBS; g++) begin : g_slice
    assign nib_slice[g] = rd_q[g*NIB_W +: NIB_W];
  end
  assign nib_rdata = nib_slice[nib_q];
endmodule

// File: rtl/cram_checker.sv
module cram_checker (
  input logic clk,
  input logic rst,
  input logic nib_req,
  input logic nib_wr,
  input logic nib_stall,
  input logic nib_rvalid,
  input logic row_req,
  input logic row_wr,
  input logic wb_oe
);
  AST_STALL_ON_CLASH: assert property (@(posedge clk) disable iff (rst)
    (nib_req && row_req) |-> nib_stall);                                  // R8
  AST_NO_STALL_ALONE: assert property (@(posedge clk) disable iff (rst)
    !row_req |-> !nib_stall);                                             // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (nib_req && !nib_wr && !row_req) |=> nib_rvalid);                     // R3
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    (nib_rvalid && !$past(rst)) |-> $past(nib_req && !nib_wr && !row_req)); // R3
  AST_BUS_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (wb_oe && !$past(rst)) |-> $past(row_req && !row_wr));                // R6
  AST_BUS_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (row_req && !row_wr) |=> wb_oe);                                      // R5
endmodule

bind dual_width_cache_ram cram_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .nib_req    (nib_req),
  .nib_wr     (nib_wr),
  .nib_stall  (nib_stall),
  .nib_rvalid (nib_rvalid),
  .row_req    (row_req),
  .row_wr     (row_wr),
  .wb_oe      (wb_oe)
);

// File: tb/dual_width_cache_ram_test.sv
`timescale 1ns/1ps
module dual_width_cache_ram_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nib_req = 0, nib_wr = 0, row_req = 0, row_wr = 0;
  logic [8:0]  nib_addr = '0;
  logic [3:0]  nib_wdata = '0;
  logic [4:0]  row_sel = '0;
  logic [3:0]  nib_rdata;
  logic        nib_rvalid, nib_stall;
  logic        tb_oe = 1'b0;
  logic [63:0] tb_drv = '0;
  wire  [63:0] row_bus;

  assign row_bus = tb_oe ? tb_drv : {64{1'bz}};

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model [32];
  logic [3:0]  exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  dual_width_cache_ram uut (
    .clk(clk), .rst(rst),
    .nib_req(nib_req), .nib_wr(nib_wr), .nib_addr(nib_addr),
    .nib_wdata(nib_wdata), .nib_rdata(nib_rdata), .nib_rvalid(nib_rvalid),
    .nib_stall(nib_stall), .row_req(row_req), .row_wr(row_wr),
    .row_sel(row_sel), .row_bus(row_bus)
  );

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(logic [63:0] w, int n);
    return w[n*4 +: 4];
  endfunction

  // scoreboard monitor for fast-path reads (R3)
  always @(negedge clk) begin
    if (!rst && nib_rvalid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: actual valid=1 expected valid=0 (no read pending)");
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (nib_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, nib_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    nib_req = 0; row_req = 0; tb_oe = 0;
  endtask

  task automatic fast_write(int r, int n, logic [3:0] d);
    @(negedge clk);
    row_req = 0; tb_oe = 0;
    nib_req = 1; nib_wr = 1; nib_addr = {r[4:0], n[3:0]}; nib_wdata = d;
    model[r][n*4 +: 4] = d;
  endtask

  task automatic fast_read(int r, int n, string tag);
    @(negedge clk);
    row_req = 0; tb_oe = 0;
    nib_req = 1; nib_wr = 0; nib_addr = {r[4:0], n[3:0]};
    exp_q.push_back(nib_of(model[r], n));
    tag_q.push_back(tag);
  endtask

  task automatic wide_write(int r, logic [63:0] d);
    @(negedge clk);
    nib_req = 0;
    row_req = 1; row_wr = 1; row_sel = r[4:0]; tb_oe = 1; tb_drv = d;
    model[r] = d;
  endtask

  task automatic wide_read(int r, string tag);
    @(negedge clk);
    nib_req = 0; tb_oe = 0;
    row_req = 1; row_wr = 0; row_sel = r[4:0];
    @(negedge clk);
    row_req = 0;
    check64(tag, row_bus, model[r]);
  endtask

  task automatic bus_free_check(string tag, logic [63:0] pat);
    @(negedge clk);
    nib_req = 0; row_req = 0; tb_oe = 1; tb_drv = pat;
    #1 check64(tag, row_bus, pat);
    tb_oe = 0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state (R9)
    repeat (3) @(negedge clk);
    check64("R9 rvalid in reset", {63'd0, nib_rvalid}, 64'd0);
    bus_free_check("R9 bus released in reset", 64'hDEAD_BEEF_0BAD_F00D);
    @(negedge clk); rst = 0;
    check64("R9 rvalid after reset", {63'd0, nib_rvalid}, 64'd0);
    bus_free_check("R9 bus released after reset", 64'h1234_5678_9ABC_DEF0);

    // fill all rows wide (R4)
    for (int r = 0; r < 32; r++)
      wide_write(r, 64'h0F1E_2D3C_4B5A_6978 * (r + 1) ^ {32{r[1:0]}});
    idle();
    wide_read(0, "R4 wide write row 0");
    wide_read(31, "R4 wide write row 31");
    wide_read(17, "R5 wide read row 17");
    idle();
    bus_free_check("R6 bus released after wide read", 64'hAAAA_5555_AAAA_5555);
    bus_free_check("R6 bus released idle", 64'h5555_AAAA_5555_AAAA);

    // nibble positions and back-to-back reads (R1, R3)
    fast_read(0, 0, "R1 row0 nibble0 bits3:0");
    fast_read(31, 15, "R1 row31 nibble15");
    fast_read(10, 7, "R3 back-to-back read");
    fast_read(10, 8, "R3 back-to-back read");
    @(negedge clk); nib_req = 0;
    #1 check64("R8 no stall without wide", {63'd0, nib_stall}, 64'd0);
    idle();

    // single nibble write (R1, R2)
    fast_write(4, 0, ~nib_of(model[4], 0));
    fast_write(12, 9, ~nib_of(model[12], 9));
    idle();
    wide_read(4, "R1 nibble0 write lands in bits 3:0");
    idle();
    wide_read(12, "R2 other 60 bits unchanged");
    idle();

    // fill row by nibbles, read wide (R7)
    for (int n = 0; n < 16; n++) fast_write(3, n, 4'(n * 7 + 3));
    idle();
    wide_read(3, "R7 nibble-filled row read wide");
    idle();
    // wide-written row read as nibbles (R7)
    wide_write(7, 64'hFEDC_BA98_7654_3210);
    for (int n = 0; n < 16; n++) fast_read(7, n, "R7 wide row read by nibble");
    idle();
    idle();

    // clash: wide read + fast write (R8)
    @(negedge clk);
    row_req = 1; row_wr = 0; row_sel = 5; tb_oe = 0;
    nib_req = 1; nib_wr = 1; nib_addr = {5'd9, 4'd2}; nib_wdata = ~nib_of(model[9], 2);
    #1 check64("R8 stall on clash", {63'd0, nib_stall}, 64'd1);
    @(negedge clk);
    nib_req = 0; row_req = 0;
    check64("R8 wide read served", row_bus, model[5]);
    check64("R8 no rvalid after stalled write", {63'd0, nib_rvalid}, 64'd0);
    idle();
    fast_read(9, 2, "R8 stalled write had no effect");
    idle();

    // clash: wide read + fast read (R8)
    @(negedge clk);
    row_req = 1; row_wr = 0; row_sel = 6; tb_oe = 0;
    nib_req = 1; nib_wr = 0; nib_addr = {5'd6, 4'd1};
    #1 check64("R8 stall on read clash", {63'd0, nib_stall}, 64'd1);
    @(negedge clk);
    nib_req = 0; row_req = 0;
    check64("R8 wide read served on read clash", row_bus, model[6]);
    check64("R8 no rvalid after stalled read", {63'd0, nib_rvalid}, 64'd0);
    idle();
    repeat (3) idle();

    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: actual %0d reads outstanding expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule